// File: doc/BRIEF.md
# Power-On Reset and Boot Fetch Sequencer

This block brings a processor subsystem from power-up to its first instruction. It receives a free-running oscillator clock and a digital indication that the core supply has reached its good level (0.8 V). From these it produces a fabric clock at one quarter of the oscillator rate and an active-low power-on reset. The reset is held low while the supply is bad. It is released only after the supply indication has stayed high for a parameterized number of consecutive fabric-clock periods.

Once reset is released, the sequencer reads two words from non-volatile memory through a request/valid read port. It reads the initial stack pointer at address 0x0 first, then the reset vector at address 0x4. It presents both words to the core and pulses a start strobe for one fabric-clock period. If the supply indication drops at any point, the sequencer returns at once to its reset state and clears what it had fetched. The whole sequence then starts again on the next good supply window.

Top module: `por_boot_seq`

## Requirements
- R1: While `rst_i` is high, at the next oscillator edge `por_n_o`, `mem_req_o` and `core_start_o` go to 0, and `init_sp_o` and `reset_vec_o` go to 0.
- R2: `fclk_o` runs at the oscillator rate divided by `DIV` (default 4) with a 50% duty cycle. It keeps running while the supply is bad.
- R3: `supply_good_i` is sampled on every oscillator edge. `por_n_o` is low while the sampled value is 0, and falls at the first oscillator edge that samples a 0.
- R4: `por_n_o` rises only after `supply_good_i` has been sampled high for `HOLD` consecutive fabric-clock periods (default 16). A single low sample, even one oscillator cycle long, restarts the count from zero.
- R5: After release, the first read presents address 0x0 and the second presents address 0x4. `mem_req_o` and `mem_addr_o` are held steady until `mem_valid_i` is seen high at a fabric-clock boundary, and the wait has no bound.
- R6: `init_sp_o` equals the word returned for address 0x0.
- R7: `reset_vec_o` equals the word returned for address 0x4 with bit 0 forced to 0.
- R8: `core_start_o` is high for exactly one fabric-clock period (`DIV` oscillator cycles), once per boot, after both words are valid. At that point `mem_req_o` is low.
- R9: A drop of `supply_good_i` during a fetch or after start drives `por_n_o` and `mem_req_o` low and clears `init_sp_o` and `reset_vec_o` within one oscillator cycle. The next boot begins again at address 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Free-running oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| supply_good_i | input | 1 | Core supply at or above its good threshold |
| mem_rdata_i | input | DATA_W | Read data from non-volatile memory |
| mem_valid_i | input | 1 | Read data valid |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Byte address of the read |
| fclk_o | output | 1 | Fabric clock, oscillator divided by DIV |
| por_n_o | output | 1 | Active-low power-on reset |
| init_sp_o | output | DATA_W | Initial stack pointer presented to the core |
| reset_vec_o | output | DATA_W | Reset vector presented to the core, bit 0 cleared |
| core_start_o | output | 1 | One fabric-period start strobe |

## Verification
The boot sequence is tried with memory responses that arrive at once, after short waits and after long waits that span several fabric periods. This shows that the fetch order and the latched words do not depend on memory latency. Vectors with an odd reset vector are mixed with vectors that are already even, which separates the bit-0 clearing from a plain copy. An all-ones word shows that no other bit is masked. For supply behaviour, a steady rise is compared with a rise interrupted by a one-cycle glitch, which separates a consecutive count from a cumulative one. A drop in the middle of the second fetch shows that the latched words are cleared and that the next boot starts again at address 0x0.

// File: rtl/por_boot_pkg.sv
package por_boot_pkg;

  typedef enum logic [2:0] {
    ST_HOLD     = 3'd0,
    ST_FETCH_SP = 3'd1,
    ST_FETCH_RV = 3'd2,
    ST_START    = 3'd3,
    ST_RUN      = 3'd4
  } boot_state_e;

endpackage

// File: rtl/por_clk_div.sv
module por_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic fclk_o,
  output logic tick_o
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          fclk_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      fclk_q <= 1'b0;
    end else begin
      if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
      fclk_q <= (cnt_q >= CW'(HALF));
    end
  end

  assign tick_o = (cnt_q == CW'(DIV - 1));
  assign fclk_o = fclk_q;

  // R2
  tick_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  // R2
  tick_in_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && $past(!rst_i)) |-> fclk_q);

endmodule

// File: rtl/por_supply_filter.sv
module por_supply_filter #(
  parameter int DIV  = 4,
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic supply_good_i,
  output logic ok_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !supply_good_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (tick_i && !ok_q) begin
      if (cnt_q == HW'(HOLD - 1)) ok_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = ok_q;

  // Checker: oscillator cycles of uninterrupted good supply, saturating.
  localparam int RUN_MIN = (HOLD - 1) * DIV + 1;
  localparam int RW      = $clog2(RUN_MIN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !supply_good_i)       run_q <= '0;
    else if (run_q != RW'(RUN_MIN + 1)) run_q <= run_q + 1'b1;
  end

  // R3
  drop_forces_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !supply_good_i |=> !ok_q);

  // R4
  hold_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ok_q) |-> (run_q >= RW'(RUN_MIN)));

endmodule

// File: rtl/por_boot_fsm.sv
module por_boot_fsm
  import por_boot_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] SP_ADDR = '0,
  parameter logic [ADDR_W-1:0] RV_ADDR = ADDR_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              supply_good_i,
  input  logic              ok_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_valid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] init_sp_o,
  output logic [DATA_W-1:0] reset_vec_o,
  output logic              core_start_o
);
  boot_state_e       state_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] rv_q;
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !supply_good_i || !ok_i) begin
      state_q <= ST_HOLD;
      sp_q    <= '0;
      rv_q    <= '0;
      req_q   <= 1'b0;
      addr_q  <= SP_ADDR;
      start_q <= 1'b0;
    end else if (tick_i) begin
      case (state_q)
        ST_HOLD: begin
          state_q <= ST_FETCH_SP;
          req_q   <= 1'b1;
          addr_q  <= SP_ADDR;
        end
        ST_FETCH_SP: if (mem_valid_i) begin
          sp_q    <= mem_rdata_i;
          state_q <= ST_FETCH_RV;
          addr_q  <= RV_ADDR;
        end
        ST_FETCH_RV: if (mem_valid_i) begin
          rv_q    <= {mem_rdata_i[DATA_W-1:1], 1'b0};
          state_q <= ST_START;
          req_q   <= 1'b0;
          start_q <= 1'b1;
        end
        ST_START: begin
          state_q <= ST_RUN;
          start_q <= 1'b0;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign mem_req_o    = req_q;
  assign mem_addr_o   = addr_q;
  assign init_sp_o    = sp_q;
  assign reset_vec_o  = rv_q;
  assign core_start_o = start_q;

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_q && supply_good_i && ok_i && !(tick_i && mem_valid_i))
      |=> (req_q && $stable(addr_q)));

  // R7
  vec_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    start_q |-> !rv_q[0]);

  // R8
  start_no_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    start_q |-> !req_q);

  // R9
  drop_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !supply_good_i |=> (!req_q && sp_q == '0 && rv_q == '0 && !start_q));

endmodule

// File: rtl/por_boot_seq.sv
module por_boot_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV    = 4,
  parameter int HOLD   = 16
) (
  input  logic              clk_osc_i,
  input  logic              rst_i,
  input  logic              supply_good_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_valid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fclk_o,
  output logic              por_n_o,
  output logic [DATA_W-1:0] init_sp_o,
  output logic [DATA_W-1:0] reset_vec_o,
  output logic              core_start_o
);
  localparam logic [ADDR_W-1:0] SP_ADDR = '0;
  localparam logic [ADDR_W-1:0] RV_ADDR = ADDR_W'(4);

  logic tick;
  logic ok;

  por_clk_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_osc_i),
    .rst_i  (rst_i),
    .fclk_o (fclk_o),
    .tick_o (tick)
  );

  por_supply_filter #(.DIV(DIV), .HOLD(HOLD)) u_filt (
    .clk_i         (clk_osc_i),
    .rst_i         (rst_i),
    .tick_i        (tick),
    .supply_good_i (supply_good_i),
    .ok_o          (ok)
  );

  por_boot_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SP_ADDR(SP_ADDR),
    .RV_ADDR(RV_ADDR)
  ) u_fsm (
    .clk_i         (clk_osc_i),
    .rst_i         (rst_i),
    .tick_i        (tick),
    .supply_good_i (supply_good_i),
    .ok_i          (ok),
    .mem_rdata_i   (mem_rdata_i),
    .mem_valid_i   (mem_valid_i),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .init_sp_o     (init_sp_o),
    .reset_vec_o   (reset_vec_o),
    .core_start_o  (core_start_o)
  );

  assign por_n_o = ok;

  // R8
  start_after_release_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
    core_start_o |-> por_n_o);

endmodule

// File: tb/tb_por_boot_seq.sv
module tb_por_boot_seq;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int DIV    = 4;
  localparam int HOLD   = 16;
  localparam int NV     = 4;

  // Vector: {stack word, vector word, wait at 0x0, wait at 0x4} (waits in osc cycles)
  localparam logic [71:0] VEC [NV] = '{
    {32'h2000_8000, 32'h0000_0101, 4'd0,  4'd0},
    {32'h2000_1FF0, 32'h0000_4A3D, 4'd7,  4'd2},
    {32'h1FFF_FFFC, 32'h0800_0200, 4'd13, 4'd15},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd3,  4'd9}
  };

  logic clk = 1'b0;
  logic rst;
  logic supply;
  logic [DATA_W-1:0] mem_rdata;
  logic mem_valid;
  logic mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic fclk, por_n, start;
  logic [DATA_W-1:0] sp, rv;

  always #4 clk = ~clk;

  por_boot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV(DIV), .HOLD(HOLD)) dut (
    .clk_osc_i(clk), .rst_i(rst), .supply_good_i(supply),
    .mem_rdata_i(mem_rdata), .mem_valid_i(mem_valid),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .fclk_o(fclk),
    .por_n_o(por_n), .init_sp_o(sp), .reset_vec_o(rv), .core_start_o(start)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [DATA_W-1:0] cur_sp, cur_rv;
  int cur_wsp, cur_wrv;
  logic [ADDR_W-1:0] log_addr [8];
  int n_log;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Memory model, driven at the falling edge
  initial begin
    logic [ADDR_W-1:0] last;
    int w;
    last = '1; w = 0;
    mem_valid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!mem_req) begin
        mem_valid = 1'b0; last = '1;
      end else if (mem_addr != last) begin
        last = mem_addr; mem_valid = 1'b0;
        w = (mem_addr == 0) ? cur_wsp : cur_wrv;
        if (n_log < 8) log_addr[n_log] = mem_addr;
        n_log++;
      end else if (w > 0) begin
        w--;
      end else begin
        mem_valid = 1'b1;
        mem_rdata = (mem_addr == 0) ? cur_sp : (mem_addr == 4) ? cur_rv : 32'hDEAD_BEEF;
      end
    end
  end

  // Watchdog
  initial begin
    cyc(150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic boot(input logic [31:0] s, input logic [31:0] v, input int ws, input int wv, input int idx);
    int t, width;
    cur_sp = s; cur_rv = v; cur_wsp = ws; cur_wrv = wv; n_log = 0;
    supply = 1'b1;
    t = 0;
    while (!start && t < 4000) begin @(negedge clk); t++; end
    chk($sformatf("R8 start seen vec%0d", idx), 64'(start), 64'd1);
    chk($sformatf("R6 stack word vec%0d", idx), 64'(sp), 64'(s));
    chk($sformatf("R7 vector bit0 clear vec%0d", idx), 64'(rv), 64'({v[31:1], 1'b0}));
    chk($sformatf("R8 no request at start vec%0d", idx), 64'(mem_req), 64'd0);
    chk($sformatf("R5 two reads vec%0d", idx), 64'(n_log), 64'd2);
    chk($sformatf("R5 first addr 0x0 vec%0d", idx), 64'(log_addr[0]), 64'h0);
    chk($sformatf("R5 second addr 0x4 vec%0d", idx), 64'(log_addr[1]), 64'h4);
    width = 0;
    while (start && width < 100) begin @(negedge clk); width++; end
    chk($sformatf("R8 start width vec%0d", idx), 64'(width), 64'(DIV));
    cyc(6 * DIV);
    chk($sformatf("R8 single strobe vec%0d", idx), 64'(start), 64'd0);
    chk($sformatf("R6 words kept vec%0d", idx), 64'(sp), 64'(s));
  endtask

  initial begin
    int hi, rises;
    logic prev;
    rst = 1'b1; supply = 1'b1;
    cur_sp = '0; cur_rv = '0; cur_wsp = 0; cur_wrv = 0; n_log = 0;
    cyc(3);
    // R1 reset state
    chk("R1 por_n in reset", 64'(por_n), 64'd0);
    chk("R1 req in reset", 64'(mem_req), 64'd0);
    chk("R1 start in reset", 64'(start), 64'd0);
    chk("R1 words in reset", 64'({sp, rv}), 64'd0);
    supply = 1'b0;
    rst = 1'b0;
    cyc(2);
    // R2 divider while supply is bad
    hi = 0; rises = 0; prev = fclk;
    for (int i = 0; i < 8 * DIV; i++) begin
      @(negedge clk);
      if (fclk) hi++;
      if (fclk && !prev) rises++;
      prev = fclk;
    end
    chk("R2 fclk rises", 64'(rises), 64'd8);
    chk("R2 fclk duty", 64'(hi), 64'(4 * DIV));
    chk("R3 por_n low while supply bad", 64'(por_n), 64'd0);

    // R4 hold window
    supply = 1'b1;
    cyc((HOLD - 1) * DIV);
    chk("R4 still held before window", 64'(por_n), 64'd0);
    supply = 1'b0; cyc(1); supply = 1'b1;
    cyc((HOLD - 1) * DIV);
    chk("R4 glitch restarts count", 64'(por_n), 64'd0);
    cyc(2 * DIV + 1);
    chk("R4 release after window", 64'(por_n), 64'd1);
    supply = 1'b0; cyc(1);
    chk("R3 por_n falls in one cycle", 64'(por_n), 64'd0);
    cyc(3);

    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      boot(VEC[k][71:40], VEC[k][39:8], int'(VEC[k][7:4]), int'(VEC[k][3:0]), k);
      supply = 1'b0; cyc(1);
      chk("R9 words cleared after drop", 64'({sp, rv}), 64'd0);
      chk("R3 por_n low after drop", 64'(por_n), 64'd0);
      cyc(3);
    end

    // R9 drop in the middle of the second fetch
    cur_sp = 32'h1234_5678; cur_rv = 32'h0000_0011; cur_wsp = 0; cur_wrv = 1000; n_log = 0;
    supply = 1'b1;
    hi = 0;
    while (!(mem_req && mem_addr == 8'h4) && hi < 4000) begin @(negedge clk); hi++; end
    cyc(5);
    chk("R5 waits on slow memory", 64'({mem_req, mem_addr}), 64'h104);
    chk("R6 stack latched before drop", 64'(sp), 64'h1234_5678);
    supply = 1'b0; cyc(1);
    chk("R9 por_n low mid-fetch", 64'(por_n), 64'd0);
    chk("R9 request dropped", 64'(mem_req), 64'd0);
    chk("R9 stack cleared", 64'(sp), 64'd0);
    cyc(3);
    boot(32'hCAFE_0000, 32'h0000_0ACF, 2, 1, 9);

    // R1 reset while running
    rst = 1'b1; cyc(1);
    chk("R1 reset clears running state", 64'({por_n, mem_req, start, sp, rv}), 64'd0);
    rst = 1'b0; supply = 1'b0;
    cyc(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule